// File: doc/BRIEF.md
# Oversampling UART Receiver with Noise Detection

This block receives asynchronous serial characters of eight data bits, no parity and one stop bit. It samples its input only on cycles where an external enable, running at sixteen times the baud rate, is high. Each bit time is split into sixteen slots, RT1 to RT16. The receiver first waits for a start edge. It then checks the start bit against noise by a 2-of-3 vote. Each later bit is decided by a majority of three samples in the middle of the bit.

Every sample that disagrees with the level finally decided for its bit marks the character as noisy. A bad stop bit sets a framing flag. A character that completes while the previous one has not been taken is an overrun. Any falling edge after the start bit pulls the slot count back to RT1, so the sample points follow the sender's bit boundaries.

Finished characters go into a single holding register, which is separate from the shift register. A read strobe takes the character. A clear strobe resets the three error flags. The input is assumed to be synchronous to the clock already.

Top module: `uart_rx_os16`

## Requirements
- R1: After reset, rx_data is 0 and data_full, noise_flag, frame_flag and overrun_flag are all 0.
- R2: While hunting, a frame starts when a tick samples rx_in as 0 and the three previous ticks all sampled it as 1. That 0 sample is slot RT1.
- R3: The start bit is accepted when at least two of the samples at RT3, RT5 and RT7 are 0. Otherwise the receiver goes back to hunting and delivers nothing.
- R4: Each data bit and the stop bit take the majority of the samples at RT8, RT9 and RT10. Data bits arrive least significant first, so the first data bit lands in rx_data bit 0. An accepted start bit counts as 0 even if its RT8 to RT10 samples are 1.
- R5: noise_flag is set when a character is delivered if any voted sample in its frame differs from its bit's decided level. Start samples are RT3, RT5, RT7, RT8, RT9 and RT10, compared against 0. Data and stop samples are RT8 to RT10.
- R6: On the tick that decides the stop bit, if frame_flag and data_full are both 0, the character is loaded into rx_data and data_full is set on that same clock edge. A one-cycle rd_stb clears data_full.
- R7: A character that completes while data_full is 1 and frame_flag is 0 sets overrun_flag and is discarded. rx_data keeps the older character.
- R8: A stop bit decided as 0 sets frame_flag, and the character is still stored. While frame_flag is 1, no completed character changes rx_data, data_full or any flag.
- R9: After the start bit, a 1 sample followed on the next tick by a 0 sample makes that 0 sample slot RT1 of a new bit.
- R10: A one-cycle flag_clr clears noise_flag, frame_flag and overrun_flag. On the same cycle it wins over any set.
- R11: When a framing error occurs on a character whose data is not all zeros, a 0 on the very next tick starts a new frame. After a break (all-zero data and a 0 stop bit), continued 0 samples start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud16_tick | input | 1 | One-cycle enable at 16 times the baud rate |
| rx_in | input | 1 | Serial data input, idle high |
| rd_stb | input | 1 | Takes the held character, clears data_full |
| flag_clr | input | 1 | Clears the noise, framing and overrun flags |
| rx_data | output | 8 | Held received character |
| data_full | output | 1 | A character is waiting in rx_data |
| noise_flag | output | 1 | A delivered character had a disagreeing sample |
| frame_flag | output | 1 | A delivered character had a 0 stop bit |
| overrun_flag | output | 1 | A character was lost because rx_data was full |

## Verification
The embedded properties check several rules on every cycle. They cover the start of a frame at RT1 after an edge and the return of the slot count to RT1 on a falling edge inside the data phase. They also cover data_full rising on delivery and falling on a read, overrun keeping the old character, a set framing flag freezing the holding register, and the clear strobe winning over a same-cycle set. The rules that depend on the shape of the line over a whole frame can only be shown by the bench's scenarios. These are the 2-of-3 start vote, majority decisions under glitches, the noise marking of disagreeing samples, tracking of a short bit period through re-alignment, and the difference between a framing error and a break in how quickly the next start is found.

// File: rtl/uart_rx_os16_pkg.sv
// Shared constants, state type and vote helper for the 16x oversampling
// receiver. Assumes slot numbering RT1..RT16 with fixed vote slots.
package uart_rx_os16_pkg;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_START,
        RX_DATA
    } rx_state_t;

    localparam int SLOTS  = 16;
    localparam int SLOT_W = $clog2(SLOTS + 1);

    // Start qualification slots and mid-bit vote slots
    localparam int SQ_A = 3;
    localparam int SQ_B = 5;
    localparam int SQ_C = 7;
    localparam int MV_A = 8;
    localparam int MV_B = 9;
    localparam int MV_C = 10;

    // Majority of three samples
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_edge_hunt.sv
// Edge hunter: keeps a short history of tick samples and reports the start
// edge (0 after HIST_LEN ones) and any 1-to-0 step. A preload request fills
// the history with ones so the next 0 sample is a start at once.
// Assumes rx_in is already synchronous to clk and HIST_LEN >= 2.
module uart_rx_edge_hunt #(
    parameter int HIST_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_in,
    input  logic preload,
    output logic start_edge,
    output logic fall_edge
);

    logic [HIST_LEN-1:0] hist;

    // Edge decode against the stored history (bit 0 is the latest sample)
    always_comb begin
        start_edge = tick && !rx_in && (&hist);
        fall_edge  = tick && !rx_in && hist[0];
    end

    // History shift on each tick, or fill with ones on preload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (tick) begin
            if (preload) hist <= '1;
            else         hist <= {hist[HIST_LEN-2:0], rx_in};
        end
    end

    // R2
    start_is_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_edge |-> fall_edge);

endmodule

// File: rtl/uart_rx_frame_engine.sv
// Frame engine: counts RT slots, qualifies the start bit, votes each bit,
// shifts data in LSB first and signals completion on the stop decision tick.
// Falling edges in the data phase re-align the slot count to RT1.
// Assumes tick is a one-cycle enable at 16x the bit rate.
module uart_rx_frame_engine
    import uart_rx_os16_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_in,
    input  logic                 start_edge,
    input  logic                 fall_edge,
    output logic                 done,
    output logic [DATA_BITS-1:0] frame_byte,
    output logic                 frame_noise,
    output logic                 stop_bad,
    output logic                 preload
);

    localparam int IDX_W = $clog2(DATA_BITS + 1);

    rx_state_t              state;
    logic [SLOT_W-1:0]      rt;
    logic [SLOT_W-1:0]      slot_now;
    logic [IDX_W-1:0]       idx;
    logic                   v_a, v_b;
    logic                   noise_acc;
    logic [DATA_BITS-1:0]   sreg;
    logic                   vote, agree3, decide, start_noisy;

    // Slot of the current sample, with re-alignment on data-phase edges
    always_comb begin
        if (state == RX_DATA && fall_edge)   slot_now = SLOT_W'(1);
        else if (rt == SLOT_W'(SLOTS))       slot_now = SLOT_W'(1);
        else                                 slot_now = rt + SLOT_W'(1);
    end

    // Votes, completion and hand-off signals
    always_comb begin
        vote        = maj3(v_a, v_b, rx_in);
        agree3      = (v_a == v_b) && (v_b == rx_in);
        decide      = tick && state == RX_DATA && slot_now == SLOT_W'(MV_C);
        done        = decide && idx == IDX_W'(DATA_BITS);
        stop_bad    = !vote;
        frame_noise = noise_acc | !agree3;
        frame_byte  = sreg;
        preload     = done && !vote && (sreg != '0);
        start_noisy = rx_in && (slot_now == SLOT_W'(SQ_A) || slot_now == SLOT_W'(SQ_B) ||
                                slot_now == SLOT_W'(SQ_C) || slot_now == SLOT_W'(MV_A) ||
                                slot_now == SLOT_W'(MV_B) || slot_now == SLOT_W'(MV_C));
    end

    // Frame sequencing, sampling and data shifting on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_HUNT;
            rt        <= '0;
            idx       <= '0;
            v_a       <= 1'b0;
            v_b       <= 1'b0;
            noise_acc <= 1'b0;
            sreg      <= '0;
        end else if (tick) begin
            case (state)
                RX_HUNT: begin
                    if (start_edge) begin
                        state     <= RX_START;
                        rt        <= SLOT_W'(1);
                        noise_acc <= 1'b0;
                    end
                end
                RX_START: begin
                    rt <= slot_now;
                    if (slot_now == SLOT_W'(SQ_A) || slot_now == SLOT_W'(MV_A)) v_a <= rx_in;
                    if (slot_now == SLOT_W'(SQ_B) || slot_now == SLOT_W'(MV_B)) v_b <= rx_in;
                    if (start_noisy) noise_acc <= 1'b1;
                    if (slot_now == SLOT_W'(SQ_C) && vote) state <= RX_HUNT;
                    if (slot_now == SLOT_W'(MV_C)) begin
                        state <= RX_DATA;
                        idx   <= '0;
                    end
                end
                RX_DATA: begin
                    rt <= slot_now;
                    if (slot_now == SLOT_W'(MV_A)) v_a <= rx_in;
                    if (slot_now == SLOT_W'(MV_B)) v_b <= rx_in;
                    if (slot_now == SLOT_W'(MV_C)) begin
                        if (!agree3) noise_acc <= 1'b1;
                        if (idx == IDX_W'(DATA_BITS)) begin
                            state <= RX_HUNT;
                        end else begin
                            sreg <= {vote, sreg[DATA_BITS-1:1]};
                            idx  <= idx + IDX_W'(1);
                        end
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end

    // R2
    start_rt1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && state == RX_HUNT && start_edge |=> state == RX_START && rt == SLOT_W'(1));

    // R9
    resync_rt1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && state == RX_DATA && fall_edge |=> state == RX_DATA && rt == SLOT_W'(1));

    // R4
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != RX_HUNT |-> rt >= SLOT_W'(1) && rt <= SLOT_W'(SLOTS));

    // R6
    done_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> state == RX_HUNT && !done);

endmodule

// File: rtl/uart_rx_char_hold.sv
// Character holding register and status flags. Loads a finished character
// when no framing error is pending and the register is empty. Otherwise it
// records an overrun, or ignores the character while a framing error is held.
// The clear strobe beats any same-cycle set.
module uart_rx_char_hold #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] frame_byte,
    input  logic                 frame_noise,
    input  logic                 stop_bad,
    input  logic                 rd_stb,
    input  logic                 flag_clr,
    output logic [DATA_BITS-1:0] data_q,
    output logic                 full_q,
    output logic                 nf_q,
    output logic                 fe_q,
    output logic                 ov_q
);

    logic accept, write, lose;

    // Delivery decision from registered flags
    always_comb begin
        accept = done && !fe_q;
        write  = accept && !full_q;
        lose   = accept && full_q;
    end

    // Holding register, full flag and error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            nf_q   <= 1'b0;
            fe_q   <= 1'b0;
            ov_q   <= 1'b0;
        end else begin
            if (write) data_q <= frame_byte;
            if (write)       full_q <= 1'b1;
            else if (rd_stb) full_q <= 1'b0;
            if (flag_clr) begin
                nf_q <= 1'b0;
                fe_q <= 1'b0;
                ov_q <= 1'b0;
            end else begin
                if (write && frame_noise) nf_q <= 1'b1;
                if (write && stop_bad)    fe_q <= 1'b1;
                if (lose)                 ov_q <= 1'b1;
            end
        end
    end

    // R6
    load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fe_q && !full_q |=> full_q && data_q == $past(frame_byte));

    // R6
    read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !done |=> !full_q);

    // R7
    overrun_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fe_q && full_q && !flag_clr |=> ov_q && $stable(data_q));

    // R8
    frame_err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && fe_q |=> $stable(data_q));

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !nf_q && !fe_q && !ov_q);

endmodule

// File: rtl/uart_rx_os16.sv
// Top of the 16x oversampling serial receiver: edge hunter, frame engine
// and character holding register. Assumes baud16_tick is a one-cycle
// enable and rx_in is synchronous to clk.
module uart_rx_os16 #(
    parameter int DATA_BITS = 8,
    parameter int HIST_LEN  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud16_tick,
    input  logic                 rx_in,
    input  logic                 rd_stb,
    input  logic                 flag_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 data_full,
    output logic                 noise_flag,
    output logic                 frame_flag,
    output logic                 overrun_flag
);

    logic                 start_edge, fall_edge, preload;
    logic                 done, frame_noise, stop_bad;
    logic [DATA_BITS-1:0] frame_byte;

    uart_rx_edge_hunt #(.HIST_LEN(HIST_LEN)) u_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud16_tick),
        .rx_in      (rx_in),
        .preload    (preload),
        .start_edge (start_edge),
        .fall_edge  (fall_edge)
    );

    uart_rx_frame_engine #(.DATA_BITS(DATA_BITS)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (baud16_tick),
        .rx_in       (rx_in),
        .start_edge  (start_edge),
        .fall_edge   (fall_edge),
        .done        (done),
        .frame_byte  (frame_byte),
        .frame_noise (frame_noise),
        .stop_bad    (stop_bad),
        .preload     (preload)
    );

    uart_rx_char_hold #(.DATA_BITS(DATA_BITS)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .frame_byte  (frame_byte),
        .frame_noise (frame_noise),
        .stop_bad    (stop_bad),
        .rd_stb      (rd_stb),
        .flag_clr    (flag_clr),
        .data_q      (rx_data),
        .full_q      (data_full),
        .nf_q        (noise_flag),
        .fe_q        (frame_flag),
        .ov_q        (overrun_flag)
    );

endmodule

// File: tb/uart_rx_os16_bench.sv
// Scoreboard bench: the driver shapes the serial line tick by tick and pushes
// expected port states into a queue; the monitor pops and compares them.
module uart_rx_os16_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud16_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       rd_stb = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_data;
    logic       data_full, noise_flag, frame_flag, overrun_flag;

    int total = 0;
    int bad = 0;

    logic [11:0] q_val[$];
    string       q_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_os16 u_uart_rx_os16 (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud16_tick  (baud16_tick),
        .rx_in        (rx_in),
        .rd_stb       (rd_stb),
        .flag_clr     (flag_clr),
        .rx_data      (rx_data),
        .data_full    (data_full),
        .noise_flag   (noise_flag),
        .frame_flag   (frame_flag),
        .overrun_flag (overrun_flag)
    );

    // One compare, counted
    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One line sample on one tick, optional clear strobe on the same cycle
    task automatic do_tick(input logic v, input logic c);
        @(negedge clk);
        rx_in = v;
        baud16_tick = 1'b1;
        flag_clr = c;
        @(negedge clk);
        baud16_tick = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) do_tick(1'b1, 1'b0);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) do_tick(1'b0, 1'b0);
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // Frame: index 0 start, 1..8 data LSB first, 9 stop; slots gfrom..gto of
    // bit gbit are inverted; blen ticks per bit; optional clear at stop RT10
    task automatic send_frame(input logic [7:0] d, input logic stopv, input int gbit,
                              input int gfrom, input int gto, input int blen, input logic clr_done);
        for (int b = 0; b < 10; b++) begin
            for (int s = 1; s <= blen; s++) begin
                logic lvl;
                lvl = (b == 0) ? 1'b0 : (b == 9) ? stopv : d[b-1];
                if (b == gbit && s >= gfrom && s <= gto) lvl = ~lvl;
                do_tick(lvl, clr_done && b == 9 && s == 10);
            end
        end
    endtask

    task automatic send_clean(input logic [7:0] d);
        send_frame(d, 1'b1, -1, 0, 0, 16, 1'b0);
    endtask

    // Data bits and stop of 16 ticks each, for a frame whose start is already running
    task automatic send_tail(input logic [7:0] d);
        for (int b = 0; b < 8; b++)
            for (int s = 0; s < 16; s++) do_tick(d[b], 1'b0);
        idle(16);
    endtask

    // Driver side of the scoreboard: queue {data, full, nf, fe, ov}
    task automatic expect_st(input logic [7:0] d, input logic f, input logic n,
                             input logic fe, input logic ov, input string req);
        q_val.push_back({d, f, n, fe, ov});
        q_req.push_back(req);
        wait (q_val.size() == 0);
        @(negedge clk);
    endtask

    // Monitor side: pop and compare against the ports
    initial begin
        forever begin
            logic [11:0] v;
            string r;
            wait (q_val.size() > 0);
            @(negedge clk);
            v = q_val[0];
            r = q_req[0];
            chk(r, "rx_data",      rx_data,             v[11:4]);
            chk(r, "data_full",    {7'd0, data_full},    {7'd0, v[3]});
            chk(r, "noise_flag",   {7'd0, noise_flag},   {7'd0, v[2]});
            chk(r, "frame_flag",   {7'd0, frame_flag},   {7'd0, v[1]});
            chk(r, "overrun_flag", {7'd0, overrun_flag}, {7'd0, v[0]});
            void'(q_val.pop_front());
            void'(q_req.pop_front());
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_st(8'h00, 0, 0, 0, 0, "R1");

        idle(20);
        // R2 R4 clean character, LSB first
        send_clean(8'hA5);
        expect_st(8'hA5, 1, 0, 0, 0, "R4");
        pulse_rd();
        expect_st(8'hA5, 0, 0, 0, 0, "R6");

        // R5 data bit 1 (level 0) reads 1 at RT10..RT16: still 0, noisy
        send_frame(8'hF0, 1'b1, 2, 10, 16, 16, 1'b0);
        expect_st(8'hF0, 1, 1, 0, 0, "R5");
        pulse_rd();
        pulse_clr();
        expect_st(8'hF0, 0, 0, 0, 0, "R10");

        // R4 start bit high at RT8..RT10 still counts as 0, marked noisy
        send_frame(8'h3C, 1'b1, 0, 8, 10, 16, 1'b0);
        expect_st(8'h3C, 1, 1, 0, 0, "R4");
        pulse_rd();
        pulse_clr();

        // R3 2-of-3 start: RT3 high, RT5 and RT7 low -> accepted, noisy
        send_frame(8'h96, 1'b1, 0, 3, 3, 16, 1'b0);
        expect_st(8'h96, 1, 1, 0, 0, "R3");
        pulse_rd();
        pulse_clr();

        // R3 only RT3 low -> rejected, nothing delivered
        zeros(3);
        idle(40);
        expect_st(8'h96, 0, 0, 0, 0, "R3");

        // R7 overrun keeps the older character
        send_clean(8'h3C);
        expect_st(8'h3C, 1, 0, 0, 0, "R6");
        send_clean(8'h55);
        expect_st(8'h3C, 1, 0, 0, 1, "R7");
        pulse_clr();
        pulse_rd();

        // R10 clear on the delivery cycle beats the noise set
        send_frame(8'h5A, 1'b1, 0, 8, 10, 16, 1'b1);
        expect_st(8'h5A, 1, 0, 0, 0, "R10");
        pulse_rd();

        // R8 framing error stores the character; later ones are blocked
        send_frame(8'h81, 1'b0, -1, 0, 0, 16, 1'b0);
        expect_st(8'h81, 1, 0, 1, 0, "R8");
        pulse_rd();
        idle(200);
        expect_st(8'h81, 0, 0, 1, 0, "R8");
        send_clean(8'h42);
        expect_st(8'h81, 0, 0, 1, 0, "R8");
        pulse_clr();
        send_clean(8'h42);
        expect_st(8'h42, 1, 0, 0, 0, "R8");
        pulse_rd();

        // R11 non-break framing error: the start found at stop RT11 carries a character
        send_frame(8'h81, 1'b0, -1, 0, 0, 16, 1'b0);
        expect_st(8'h81, 1, 0, 1, 0, "R8");
        pulse_clr();
        pulse_rd();
        zeros(10);
        send_tail(8'h6B);
        expect_st(8'h6B, 1, 0, 0, 0, "R11");
        pulse_rd();

        // R11 break: continued zeros start no frame
        send_frame(8'h00, 1'b0, -1, 0, 0, 16, 1'b0);
        expect_st(8'h00, 1, 0, 1, 0, "R11");
        pulse_clr();
        pulse_rd();
        zeros(10);
        idle(180);
        expect_st(8'h00, 0, 0, 0, 0, "R11");

        // R9 15-tick bits are tracked by re-alignment on falling edges
        send_frame(8'h55, 1'b1, -1, 0, 0, 15, 1'b0);
        idle(10);
        expect_st(8'h55, 1, 0, 0, 0, "R9");
        pulse_rd();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule